// File: doc/BRIEF.md
# Programmable Interval Waveform Sequencer

This block plays short, host-programmed control waveforms onto a parallel bus. It stores four programs. Each program has seven active intervals, numbered 0 to 6, and interval number 7 stands for idle. A host loads the programs through a simple byte-write port. A program is launched by a start request that carries a transfer kind: FIFO write, FIFO read, single read or single write. A small mapping register turns the kind into a program number.

While a program runs, every interval does one of two things:
- It holds a six-bit control pattern, plus optional data-enable, data-advance and interrupt actions, for a programmed number of cycles.
- It is a one-cycle decision. The decision combines two synchronized ready inputs with a selectable logic function and jumps to one of two target intervals.

Stepping past interval 6, or jumping to interval 7, ends the program. An abort returns the engine to idle at once. While idle, the control outputs show a separately programmable idle pattern.

Top module: `wave_seq`

## Requirements
- R1: After reset the engine is idle. `done`=1, `ctl_out`=6'h3F (the idle pattern resets to all ones), and `data_en`, `data_next` and `irq` are 0.
- R2: Descriptor byte address = program*32 + group*8 + interval. The groups are: 0 length/targets, 1 opcode, 2 control output, 3 logic function.
- R3: A start seen at a rising edge while idle launches a program at interval 0 in the next cycle, and `done` drops. The program number is `map[2k+1:2k]` for `start_kind` k (0 FIFO write, 1 FIFO read, 2 single read, 3 single write). `map` resets to 8'hE4, which maps each kind k to program k, and can be written.
- R4: A timed interval (opcode bit 0 clear) with length byte L lasts L cycles, and a length of 0 lasts one cycle. It is followed by the interval with the next index.
- R5: A decision interval (opcode bit 0 set) lasts exactly one cycle. It then moves to length bits [5:3] when the condition is true and to bits [2:0] when it is false.
- R6: In the logic-function byte, bits [5:3] select ready term A, bits [2:0] select ready term B, and bits [7:6] select the function: 00 A AND B, 01 A OR B, 10 A XOR B, 11 A AND NOT B. Ready indices 6 and 7 read as 0.
- R7: While running, `ctl_out` equals bits [5:0] of the current interval's output byte. While idle it equals the idle pattern, which the host can rewrite.
- R8: `data_en` is high for every cycle of an interval whose opcode bit 1 is set, and is low while idle.
- R9: `data_next` pulses in the last cycle of an interval whose opcode bit 2 is set.
- R10: `irq` pulses in the first cycle of each entry into an interval whose opcode bit 4 is set.
- R11: Reaching interval 7 ends the program, and `done` is 1 in the following cycle.
- R12: An abort seen at a rising edge makes the engine idle in the next cycle. An abort beats a start at the same edge.
- R13: A start request that arrives while a program is running is ignored.
- R14: Each ready input passes through two flip-flops. A decision uses the value that was present two rising edges earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| desc_we | input | 1 | Descriptor byte write strobe |
| desc_addr | input | 7 | Descriptor byte address |
| desc_wdata | input | 8 | Descriptor byte data |
| idle_we | input | 1 | Idle pattern write strobe |
| idle_wdata | input | 6 | New idle control pattern |
| map_we | input | 1 | Kind-to-program map write strobe |
| map_wdata | input | 8 | New map, two bits per kind |
| start | input | 1 | Start request |
| start_kind | input | 2 | Transfer kind of the start request |
| abort | input | 1 | Return to idle |
| rdy_in | input | 6 | Asynchronous ready inputs |
| ctl_out | output | 6 | Control outputs |
| data_en | output | 1 | Data bus enable |
| data_next | output | 1 | Data advance strobe |
| irq | output | 1 | Interrupt pulse |
| done | output | 1 | High while idle |

## Verification
The first interval's outputs are due in the cycle after the edge that accepts a start. Each later interval appears one edge after the previous interval's last cycle. `done` returns one edge after the final interval, or one edge after an abort. A ready change reaches a decision only after two edges.

The bench drives every input just after a falling edge and samples at the next falling edge. It walks its own cycle-by-cycle model of the program in step with the design, so each comparison lands in exactly the cycle the rules above name. In the synchronizer test, the ready input changes in the same cycle as the start request and again one cycle earlier, and the expected branch differs between the two.

// File: rtl/wave_seq_pkg.sv
package wave_seq_pkg;
  localparam int IV_W    = 3;
  localparam int NUM_IV  = 1 << IV_W;
  localparam logic [IV_W-1:0] IV_IDLE = 3'd7;

  localparam int GRP_W   = 2;
  localparam int NUM_GRP = 1 << GRP_W;
  localparam int GRP_LEN = 0;
  localparam int GRP_OP  = 1;
  localparam int GRP_OUT = 2;
  localparam int GRP_LFN = 3;

  localparam int OP_DEC  = 0;
  localparam int OP_DATA = 1;
  localparam int OP_NEXT = 2;
  localparam int OP_IRQ  = 4;

  localparam int NUM_KIND = 4;

  typedef enum logic [1:0] {
    LF_AND  = 2'b00,
    LF_OR   = 2'b01,
    LF_XOR  = 2'b10,
    LF_ANDN = 2'b11
  } lfunc_e;

  typedef struct packed {
    logic [7:0] lfn;
    logic [7:0] outp;
    logic [7:0] op;
    logic [7:0] len;
  } desc_t;
endpackage

// File: rtl/wave_seq_mem.sv
module wave_seq_mem
  import wave_seq_pkg::*;
#(
  parameter int WF_W = 2
) (
  input  logic                         clk,
  input  logic                         we,
  input  logic [WF_W+GRP_W+IV_W-1:0]   waddr,
  input  logic [7:0]                   wdata,
  input  logic [WF_W+IV_W-1:0]         raddr,
  output desc_t                        rd
);
  localparam int AW    = WF_W + GRP_W + IV_W;
  localparam int DEPTH = 1 << (WF_W + IV_W);

  logic [WF_W+IV_W-1:0] bank_idx;
  logic [7:0]           rd_b [NUM_GRP];

  assign bank_idx = {waddr[AW-1 -: WF_W], waddr[IV_W-1:0]};

  // One bank per descriptor group, so all four bytes of an interval read at once
  for (genvar g = 0; g < NUM_GRP; g++) begin : g_bank
    logic [7:0] bank [DEPTH];
    always_ff @(posedge clk) begin
      if (we && (waddr[IV_W +: GRP_W] == GRP_W'(g)))
        bank[bank_idx] <= wdata;
    end
    assign rd_b[g] = bank[raddr];
  end

  assign rd.len  = rd_b[GRP_LEN];
  assign rd.op   = rd_b[GRP_OP];
  assign rd.outp = rd_b[GRP_OUT];
  assign rd.lfn  = rd_b[GRP_LFN];
endmodule

// File: rtl/wave_seq_sync.sv
module wave_seq_sync #(
  parameter int W      = 6,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) st[i] <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/wave_seq_core.sv
module wave_seq_core
  import wave_seq_pkg::*;
#(
  parameter int WF_W  = 2,
  parameter int RDY_N = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [WF_W-1:0]   start_wf,
  input  logic              abort,
  input  logic [RDY_N-1:0]  rdy,
  input  desc_t             d,
  output logic              busy,
  output logic [WF_W-1:0]   wf,
  output logic [IV_W-1:0]   iv,
  output logic              data_en,
  output logic              data_next,
  output logic              irq
);
  logic            busy_q;
  logic [WF_W-1:0] wf_q;
  logic [IV_W-1:0] iv_q;
  logic [7:0]      cnt_q;

  logic            is_dec, len_done, last, cond, term_a, term_b;
  logic [7:0]      rdy_x;
  logic [IV_W-1:0] nxt_iv;
  lfunc_e          fn;

  always_comb begin
    rdy_x = '0;
    rdy_x[RDY_N-1:0] = rdy;
  end

  assign is_dec   = d.op[OP_DEC];
  assign term_a   = rdy_x[d.lfn[5:3]];
  assign term_b   = rdy_x[d.lfn[2:0]];
  assign fn       = lfunc_e'(d.lfn[7:6]);

  always_comb begin
    case (fn)
      LF_AND:  cond = term_a & term_b;
      LF_OR:   cond = term_a | term_b;
      LF_XOR:  cond = term_a ^ term_b;
      default: cond = term_a & ~term_b;
    endcase
  end

  // zero length behaves as one cycle
  assign len_done = ({1'b0, cnt_q} + 9'd1) >= {1'b0, d.len};
  assign last     = is_dec | len_done;
  assign nxt_iv   = is_dec ? (cond ? d.len[5:3] : d.len[2:0]) : iv_q + 3'd1;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      wf_q   <= '0;
      iv_q   <= IV_IDLE;
      cnt_q  <= '0;
    end else if (abort) begin
      busy_q <= 1'b0;
      iv_q   <= IV_IDLE;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q <= 1'b1;
        wf_q   <= start_wf;
        iv_q   <= '0;
        cnt_q  <= '0;
      end
    end else if (last) begin
      cnt_q <= '0;
      iv_q  <= nxt_iv;
      if (nxt_iv == IV_IDLE) busy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 8'd1;
    end
  end

  assign busy      = busy_q;
  assign wf        = wf_q;
  assign iv        = iv_q;
  assign data_en   = busy_q & d.op[OP_DATA];
  assign data_next = busy_q & last & d.op[OP_NEXT];
  assign irq       = busy_q & d.op[OP_IRQ] & (cnt_q == '0);

  logic unused_core;
  assign unused_core = ^{d.outp, d.op[7:5], d.op[3], d.len[7:6]};
endmodule

// File: rtl/wave_seq.sv
module wave_seq
  import wave_seq_pkg::*;
#(
  parameter int NUM_WF = 4,
  parameter int CTL_W  = 6,
  parameter int RDY_N  = 6,
  parameter int SYNC_N = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          desc_we,
  input  logic [$clog2(NUM_WF)+GRP_W+IV_W-1:0] desc_addr,
  input  logic [7:0]                    desc_wdata,
  input  logic                          idle_we,
  input  logic [CTL_W-1:0]              idle_wdata,
  input  logic                          map_we,
  input  logic [NUM_KIND*$clog2(NUM_WF)-1:0] map_wdata,
  input  logic                          start,
  input  logic [1:0]                    start_kind,
  input  logic                          abort,
  input  logic [RDY_N-1:0]              rdy_in,
  output logic [CTL_W-1:0]              ctl_out,
  output logic                          data_en,
  output logic                          data_next,
  output logic                          irq,
  output logic                          done
);
  localparam int WF_W  = $clog2(NUM_WF);
  localparam int MAP_W = NUM_KIND * WF_W;

  function automatic logic [MAP_W-1:0] map_init();
    logic [MAP_W-1:0] r;
    r = '0;
    for (int k = 0; k < NUM_KIND; k++) r[k*WF_W +: WF_W] = WF_W'(k % NUM_WF);
    return r;
  endfunction

  logic [CTL_W-1:0] idle_pat_q;
  logic [MAP_W-1:0] map_q;
  logic [WF_W-1:0]  start_wf, wf_w;
  logic [IV_W-1:0]  iv_w;
  logic [RDY_N-1:0] rdy_s;
  logic             busy_w;
  desc_t            d_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      idle_pat_q <= '1;
      map_q      <= map_init();
    end else begin
      if (idle_we) idle_pat_q <= idle_wdata;
      if (map_we)  map_q      <= map_wdata;
    end
  end

  assign start_wf = map_q[start_kind*WF_W +: WF_W];

  wave_seq_mem #(.WF_W(WF_W)) u_mem (
    .clk   (clk),
    .we    (desc_we),
    .waddr (desc_addr),
    .wdata (desc_wdata),
    .raddr ({wf_w, iv_w}),
    .rd    (d_w)
  );

  wave_seq_sync #(.W(RDY_N), .STAGES(SYNC_N)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (rdy_in),
    .q   (rdy_s)
  );

  wave_seq_core #(.WF_W(WF_W), .RDY_N(RDY_N)) u_core (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .start_wf  (start_wf),
    .abort     (abort),
    .rdy       (rdy_s),
    .d         (d_w),
    .busy      (busy_w),
    .wf        (wf_w),
    .iv        (iv_w),
    .data_en   (data_en),
    .data_next (data_next),
    .irq       (irq)
  );

  assign ctl_out = busy_w ? d_w.outp[CTL_W-1:0] : idle_pat_q;
  assign done    = ~busy_w;

  logic unused_top;
  assign unused_top = ^{d_w.outp[7:CTL_W]};
endmodule

// File: rtl/wave_seq_chk.sv
module wave_seq_chk #(
  parameter int CTL_W = 6,
  parameter int WF_W  = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             abort,
  input logic             done,
  input logic [CTL_W-1:0] ctl_out,
  input logic [CTL_W-1:0] idle_pat,
  input logic             data_en,
  input logic             data_next,
  input logic             irq,
  input logic [WF_W-1:0]  wf_sel
);
  // R1
  a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (done && ctl_out == '1));

  // R3
  a_r3_start_runs: assert property (@(posedge clk) disable iff (rst)
    (done && start && !abort) |=> !done);

  // R7
  a_r7_idle_pattern: assert property (@(posedge clk) disable iff (rst)
    done |-> (ctl_out == idle_pat));

  // R8
  a_r8_quiet_when_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> (!data_en && !irq && !data_next));

  // R12
  a_r12_abort_idles: assert property (@(posedge clk) disable iff (rst)
    abort |=> done);

  // R13
  a_r13_program_held: assert property (@(posedge clk) disable iff (rst)
    !done |=> (done || $stable(wf_sel)));
endmodule

bind wave_seq wave_seq_chk #(.CTL_W(CTL_W), .WF_W(WF_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .abort     (abort),
  .done      (done),
  .ctl_out   (ctl_out),
  .idle_pat  (idle_pat_q),
  .data_en   (data_en),
  .data_next (data_next),
  .irq       (irq),
  .wf_sel    (wf_w)
);

// File: tb/wave_seq_bench.sv
module wave_seq_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       desc_we = 1'b0;
  logic [6:0] desc_addr = '0;
  logic [7:0] desc_wdata = '0;
  logic       idle_we = 1'b0;
  logic [5:0] idle_wdata = '0;
  logic       map_we = 1'b0;
  logic [7:0] map_wdata = '0;
  logic       start = 1'b0;
  logic [1:0] start_kind = '0;
  logic       abort = 1'b0;
  logic [5:0] rdy_in = '0;
  logic [5:0] ctl_out;
  logic       data_en, data_next, irq, done;

  wave_seq u_wave_seq (
    .clk(clk), .rst(rst), .desc_we(desc_we), .desc_addr(desc_addr),
    .desc_wdata(desc_wdata), .idle_we(idle_we), .idle_wdata(idle_wdata),
    .map_we(map_we), .map_wdata(map_wdata), .start(start),
    .start_kind(start_kind), .abort(abort), .rdy_in(rdy_in),
    .ctl_out(ctl_out), .data_en(data_en), .data_next(data_next),
    .irq(irq), .done(done)
  );

  always #2 clk = ~clk;

  logic [7:0] img [128];
  logic [7:0] map_m  = 8'hE4;
  logic [5:0] idle_m = 6'h3F;
  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // R6: condition from the logic-function byte
  function automatic bit eval_cond(input logic [7:0] lf, input logic [5:0] r);
    int ai, bi;
    bit ta, tb;
    ai = int'(lf[5:3]);
    bi = int'(lf[2:0]);
    ta = (ai < 6) ? r[ai] : 1'b0;
    tb = (bi < 6) ? r[bi] : 1'b0;
    case (lf[7:6])
      2'b00:   return ta & tb;
      2'b01:   return ta | tb;
      2'b10:   return ta ^ tb;
      default: return ta & ~tb;
    endcase
  endfunction

  // R2: address = program*32 + group*8 + interval
  task automatic set_iv(input int wf, input int iv, input logic [7:0] len,
                        input logic [7:0] op, input logic [7:0] outb, input logic [7:0] lf);
    img[wf*32 + iv]      = len;
    img[wf*32 + 8 + iv]  = op;
    img[wf*32 + 16 + iv] = outb;
    img[wf*32 + 24 + iv] = lf;
  endtask

  task automatic gen_rand(input int wf);
    for (int iv = 0; iv < 8; iv++) begin
      bit dec;
      logic [7:0] len, op;
      dec = ($urandom % 4) == 0;
      op  = {3'b000, 1'($urandom % 4 == 0), 1'b0, 1'($urandom), 1'($urandom), dec};
      if (dec) len = {2'b00, 3'($urandom), 3'($urandom)};
      else     len = ($urandom % 8 == 0) ? 8'd0 : 8'(1 + $urandom % 5);
      set_iv(wf, iv, len, op, 8'($urandom), 8'($urandom));
    end
  endtask

  task automatic load_range(input int base, input int n);
    for (int i = base; i < base + n; i++) begin
      desc_we = 1'b1; desc_addr = 7'(i); desc_wdata = img[i];
      @(negedge clk);
    end
    desc_we = 1'b0;
  endtask

  task automatic run_wave(input logic [1:0] kind, input logic [5:0] rdy_seen,
                          input int cap, input bit inject);
    int wf, iv, c, steps, L, base, n;
    bit running, dec, last;
    logic [7:0] len, op, outb, lf;
    start = 1'b1; start_kind = kind;
    @(negedge clk);
    start = 1'b0;
    wf = int'(map_m[kind*2 +: 2]);
    iv = 0; c = 0; steps = 0; running = 1'b1;
    while (running && steps < cap) begin
      base = wf*32 + iv;
      len = img[base]; op = img[base+8]; outb = img[base+16]; lf = img[base+24];
      dec  = op[0];
      L    = (len == 0) ? 1 : int'(len);
      last = dec || (c == L - 1);
      if (inject && steps == 1) begin start = 1'b1; start_kind = kind + 2'd1; end
      else start = 1'b0;
      chk("R3", "done low while running", int'(done), 0);
      chk("R7", "ctl_out", int'(ctl_out), int'(outb[5:0]));
      chk("R8", "data_en", int'(data_en), int'(op[1]));
      chk("R10", "irq", int'(irq), int'(op[4] && c == 0));
      chk("R9", "data_next", int'(data_next), int'(op[2] && last));
      if (last) begin
        // R4 R5: next interval
        if (dec) n = eval_cond(lf, rdy_seen) ? int'(len[5:3]) : int'(len[2:0]);
        else     n = iv + 1;
        c = 0;
        if (n == 7) running = 1'b0; else iv = n;
      end else c++;
      steps++;
      @(negedge clk);
    end
    start = 1'b0;
    if (running) begin
      abort = 1'b1;
      @(negedge clk);
      abort = 1'b0;
      chk("R12", "done after abort", int'(done), 1);
    end else begin
      chk("R11", "done after interval 7", int'(done), 1);
    end
    chk("R7", "idle pattern after run", int'(ctl_out), int'(idle_m));
  endtask

  task automatic settle_rdy(input logic [5:0] v);
    rdy_in = v;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [5:0] r;
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R1
    chk("R1", "done", int'(done), 1);
    chk("R1", "ctl_out", int'(ctl_out), 'h3F);
    chk("R1", "data_en", int'(data_en), 0);
    chk("R1", "irq", int'(irq), 0);
    chk("R1", "data_next", int'(data_next), 0);

    // random programs under the reset map (R3)
    for (int w = 0; w < 4; w++) gen_rand(w);
    load_range(0, 128);
    for (int k = 0; k < 4; k++) begin
      r = 6'($urandom);
      settle_rdy(r);
      run_wave(2'(k), r, 80, 1'b0);
    end

    // directed program 0: lengths 0/2/5, XOR decision, branch to idle (R4 R5 R6 R11)
    set_iv(0, 0, 8'd0,  8'h12, 8'h05, 8'h00);
    set_iv(0, 1, 8'd2,  8'h04, 8'h0A, 8'h00);
    set_iv(0, 2, 8'h2B, 8'h01, 8'h1C, 8'h81);
    set_iv(0, 3, 8'd1,  8'h00, 8'h30, 8'h00);
    set_iv(0, 4, 8'd1,  8'h10, 8'h11, 8'h00);
    set_iv(0, 5, 8'd5,  8'h06, 8'h22, 8'h00);
    set_iv(0, 6, 8'h3F, 8'h11, 8'h3C, 8'hF0);
    load_range(0, 32);
    settle_rdy(6'b000001);
    run_wave(2'd0, 6'b000001, 80, 1'b0);   // R6 XOR true -> 5
    settle_rdy(6'b000011);
    run_wave(2'd0, 6'b000011, 80, 1'b0);   // R6 XOR false -> 3

    // R13: start during a run is ignored
    run_wave(2'd0, 6'b000011, 80, 1'b1);

    // R12: abort in the middle of interval 1
    run_wave(2'd0, 6'b000011, 2, 1'b0);

    // R12: abort beats start while idle
    abort = 1'b1; start = 1'b1; start_kind = 2'd0;
    @(negedge clk);
    abort = 1'b0; start = 1'b0;
    chk("R12", "done with abort and start", int'(done), 1);
    @(negedge clk);
    chk("R12", "still idle", int'(done), 1);

    // R14: decision at interval 0 of program 3 sees a synchronized ready
    set_iv(3, 0, 8'h0A, 8'h01, 8'h3E, 8'h00);
    set_iv(3, 1, 8'd1,  8'h00, 8'h15, 8'h00);
    set_iv(3, 2, 8'h3F, 8'h01, 8'h2A, 8'h00);
    load_range(96, 32);
    settle_rdy(6'b000000);
    rdy_in = 6'b000001;
    run_wave(2'd3, 6'b000000, 20, 1'b0);   // R14 change too late: old value
    settle_rdy(6'b000000);
    rdy_in = 6'b000001;
    @(negedge clk);
    run_wave(2'd3, 6'b000001, 20, 1'b0);   // R14 two edges: new value

    // R3: rewritten map, kind 0 -> program 3
    map_we = 1'b1; map_wdata = 8'h1B;
    @(negedge clk);
    map_we = 1'b0; map_m = 8'h1B;
    settle_rdy(6'b000001);
    run_wave(2'd0, 6'b000001, 20, 1'b0);
    run_wave(2'd3, 6'b000001, 80, 1'b0);   // kind 3 -> program 0
    map_we = 1'b1; map_wdata = 8'hE4;
    @(negedge clk);
    map_we = 1'b0; map_m = 8'hE4;

    // R7: new idle pattern
    idle_we = 1'b1; idle_wdata = 6'h2D;
    @(negedge clk);
    idle_we = 1'b0; idle_m = 6'h2D;
    chk("R7", "idle pattern written", int'(ctl_out), 'h2D);
    run_wave(2'd3, 6'b000001, 20, 1'b0);

    // constrained random programs
    for (int it = 0; it < 14; it++) begin
      int w;
      w = int'($urandom % 4);
      gen_rand(w);
      load_range(w*32, 32);
      r = 6'($urandom);
      settle_rdy(r);
      run_wave(2'($urandom), r, 60, ($urandom % 3) == 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule